// File: doc/BRIEF.md
# In-Band ECC Request Splitter

This block sits between a request source and a memory controller whose memory has no separate ECC devices. The check bits are kept in the same memory, in a carve-out that takes one thirty-second of the address space. For every request the block decides whether it needs protection. If it does, the block sends two beats downstream in a fixed order: the data access comes first, then the access to the 64-byte line that holds its check bits. The check-bit arithmetic is done outside the block. Encoded check bits arrive with a write, and decoder verdicts arrive as error reports.

Protection is chosen by a two-bit mode. One mode protects nothing, one protects everything, and one protects only addresses that match one of two programmable base/mask windows. A test-only injection control flips chosen check bits on the write path, so that a later read of the same location shows an error. Error reports go into a single-entry log. The log keeps the first report until software clears it and flags any report that arrives while it is full.

Top module: `inband_ecc_splitter`

## Requirements
- R1: In mode 0, a request is protected when, for at least one enabled window g, `(up_addr & cfg_rng_mask[g]) == cfg_rng_base[g]`. Otherwise it passes as a single beat.
- R2: In modes 1 and 3, every request that is not denied goes downstream as exactly one beat, with `dn_is_ecc` low and `dn_wecc` zero.
- R3: In mode 2, every request that is not denied is protected, whatever the windows hold.
- R4: A protected request first issues a data beat. That beat has `dn_is_ecc`=0, `dn_addr`=`up_addr` and `dn_wdata`=`up_wdata`. After it is accepted, the block issues a check-line beat. That beat has `dn_is_ecc`=1, `dn_wdata`=0 and `dn_addr` = `cfg_ecc_base + ((up_addr >> 5) & ~63)`. `dn_write` follows `up_write` on both beats.
- R5: `up_ready` rises only in the cycle where the last downstream beat of the request is accepted. While `dn_valid` is high and `dn_ready` is low, the downstream beat holds its address and kind.
- R6: A request whose top 5 address bits equal the top 5 bits of `cfg_ecc_base` falls inside the carve-out. Such a request completes in one cycle with `up_denied` high and produces no downstream beat.
- R7: On the check-line beat of a protected write, `dn_wecc` = `up_wecc` XOR (`cfg_inj_mask` when `cfg_inj_en` is high, else 0). Reads carry `dn_wecc` = `up_wecc` on their check-line beat, with no injection.
- R8: The mode is sampled only in cycles with no pending request (`up_valid` low, or the request completing). A new mode therefore applies from the next cycle, and never part-way through a split.
- R9: An error report (`err_in`) arriving while the log is empty is captured (address, syndrome, and `err_ue_in` as type, 1 = uncorrectable) on the next edge. `log_valid` and `irq` are then high.
- R10: A report arriving while the log is full, without a clear, sets the sticky `log_ovf` and leaves the entry unchanged. `log_clr` empties the log and clears `log_ovf`. A report arriving in the same cycle as a clear is captured.
- R11: After reset, the mode reads as 1 (unprotected), no split is pending, `dn_valid` is low, and the log is empty with `log_ovf` and `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode | input | 2 | Protection mode: 0 window, 1 none, 2 all, 3 none |
| cfg_rng_en | input | 2 | Enable for each protection window |
| cfg_rng_base | input | 2x32 | Window match values |
| cfg_rng_mask | input | 2x32 | Window compare masks |
| cfg_ecc_base | input | 32 | Base of the check-bit carve-out, aligned to its size |
| cfg_inj_en | input | 1 | Test-only check-bit corruption enable |
| cfg_inj_mask | input | 8 | Check bits to flip on protected writes |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Upstream request complete |
| up_write | input | 1 | 1 = write, 0 = read |
| up_addr | input | 32 | Request byte address |
| up_wdata | input | 64 | Write data |
| up_wecc | input | 8 | Check bits from the external encoder |
| up_denied | output | 1 | Request hit the carve-out and was dropped |
| dn_valid | output | 1 | Downstream beat valid |
| dn_ready | input | 1 | Downstream beat accepted |
| dn_write | output | 1 | Downstream beat direction |
| dn_addr | output | 32 | Downstream beat address |
| dn_wdata | output | 64 | Downstream data (data beat) |
| dn_wecc | output | 8 | Downstream check bits (check-line beat) |
| dn_is_ecc | output | 1 | Beat targets a check-bit line |
| err_in | input | 1 | Error report from external decoder |
| err_addr_in | input | 32 | Failing address |
| err_syn_in | input | 8 | Failing syndrome |
| err_ue_in | input | 1 | 1 = uncorrectable, 0 = corrected |
| log_clr | input | 1 | Write-one-to-clear pulse for the log |
| log_valid | output | 1 | Log holds an entry |
| log_addr | output | 32 | Logged address |
| log_syn | output | 8 | Logged syndrome |
| log_ue | output | 1 | Logged type |
| log_ovf | output | 1 | Sticky overflow |
| irq | output | 1 | Interrupt while log is valid |

## Verification
The state that matters is the split phase. A wrong phase shows up in the very cycle it goes wrong: either a check-line beat is missing or extra on `dn_is_ecc`, or `up_ready` comes one beat early or late. A stale or early-latched mode shows up as a wrong beat count on the first request after a mode change, which is why mode changes are applied in the middle of a split. Log corruption shows up one edge after the report, on `log_valid`, `log_ovf` or the logged fields. The reference model compares every one of these on every cycle.

// File: rtl/iecc_pkg.sv
package iecc_pkg;
  typedef enum logic [1:0] {
    MODE_RANGE = 2'd0,
    MODE_OFF   = 2'd1,
    MODE_ALL   = 2'd2,
    MODE_OFF3  = 2'd3
  } iecc_mode_e;

  typedef enum logic {
    PH_DATA = 1'b0,
    PH_ECC  = 1'b1
  } iecc_phase_e;
endpackage

// File: rtl/iecc_prot_decode.sv
module iecc_prot_decode
  import iecc_pkg::*;
#(
  parameter int AW          = 32,
  parameter int NRANGE      = 2,
  parameter int CARVE_SHIFT = 5,
  parameter int LINE_BYTES  = 64
) (
  input  iecc_mode_e                 mode,
  input  logic [AW-1:0]              addr,
  input  logic [NRANGE-1:0]          rng_en,
  input  logic [NRANGE-1:0][AW-1:0]  rng_base,
  input  logic [NRANGE-1:0][AW-1:0]  rng_mask,
  input  logic [AW-1:0]              ecc_base,
  output logic                       prot,
  output logic                       reserved_hit,
  output logic [AW-1:0]              ecc_addr
);
  localparam logic [AW-1:0] LINE_MASK = AW'(LINE_BYTES - 1);

  // check-line address: carve-out base plus scaled address, line aligned
  function automatic logic [AW-1:0] ecc_line_of(input logic [AW-1:0] base,
                                                input logic [AW-1:0] a);
    return base + ((a >> CARVE_SHIFT) & ~LINE_MASK);
  endfunction

  // carve-out covers 1/2**CARVE_SHIFT of the space at an aligned base
  function automatic logic in_carve(input logic [AW-1:0] base,
                                    input logic [AW-1:0] a);
    return a[AW-1 -: CARVE_SHIFT] == base[AW-1 -: CARVE_SHIFT];
  endfunction

  logic [NRANGE-1:0] win_hit;

  for (genvar g = 0; g < NRANGE; g++) begin : g_win
    assign win_hit[g] = rng_en[g] && ((addr & rng_mask[g]) == rng_base[g]);
  end

  always_comb begin
    case (mode)
      MODE_RANGE: prot = |win_hit;
      MODE_ALL:   prot = 1'b1;
      default:    prot = 1'b0;
    endcase
  end

  assign reserved_hit = in_carve(ecc_base, addr);
  assign ecc_addr     = ecc_line_of(ecc_base, addr);
endmodule

// File: rtl/iecc_split_ctrl.sv
module iecc_split_ctrl
  import iecc_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 64,
  parameter int EW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_mode,
  input  logic          cfg_inj_en,
  input  logic [EW-1:0] cfg_inj_mask,
  input  logic          prot,
  input  logic          reserved_hit,
  input  logic [AW-1:0] ecc_addr,
  output iecc_mode_e    mode_q,
  input  logic          up_valid,
  output logic          up_ready,
  input  logic          up_write,
  input  logic [AW-1:0] up_addr,
  input  logic [DW-1:0] up_wdata,
  input  logic [EW-1:0] up_wecc,
  output logic          up_denied,
  output logic          dn_valid,
  input  logic          dn_ready,
  output logic          dn_write,
  output logic [AW-1:0] dn_addr,
  output logic [DW-1:0] dn_wdata,
  output logic [EW-1:0] dn_wecc,
  output logic          dn_is_ecc,
  output logic          fire_data,
  output logic          fire_ecc
);
  iecc_phase_e phase_q, phase_d;
  logic        mode_load;
  logic [EW-1:0] inj_flip;

  assign inj_flip  = (cfg_inj_en && up_write) ? cfg_inj_mask : '0;
  assign mode_load = !up_valid || up_ready;

  always_comb begin
    dn_valid  = 1'b0;
    up_ready  = 1'b0;
    up_denied = 1'b0;
    dn_is_ecc = 1'b0;
    dn_addr   = up_addr;
    dn_wdata  = up_wdata;
    dn_wecc   = '0;
    if (up_valid) begin
      if (phase_q == PH_DATA) begin
        if (reserved_hit) begin
          up_ready  = 1'b1;
          up_denied = 1'b1;
        end else begin
          dn_valid = 1'b1;
          up_ready = !prot && dn_ready;
        end
      end else begin
        dn_valid  = 1'b1;
        dn_is_ecc = 1'b1;
        dn_addr   = ecc_addr;
        dn_wdata  = '0;
        dn_wecc   = up_wecc ^ inj_flip;
        up_ready  = dn_ready;
      end
    end
  end

  assign dn_write  = up_write;
  assign fire_data = dn_valid && dn_ready && !dn_is_ecc;
  assign fire_ecc  = dn_valid && dn_ready && dn_is_ecc;

  always_comb begin
    phase_d = phase_q;
    if (phase_q == PH_DATA && fire_data && prot) phase_d = PH_ECC;
    else if (phase_q == PH_ECC && fire_ecc)      phase_d = PH_DATA;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_DATA;
      mode_q  <= MODE_OFF;
    end else begin
      phase_q <= phase_d;
      if (mode_load) mode_q <= iecc_mode_e'(cfg_mode);
    end
  end
endmodule

// File: rtl/iecc_err_log.sv
module iecc_err_log #(
  parameter int AW = 32,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          err_in,
  input  logic [AW-1:0] err_addr_in,
  input  logic [SW-1:0] err_syn_in,
  input  logic          err_ue_in,
  input  logic          log_clr,
  output logic          log_valid,
  output logic [AW-1:0] log_addr,
  output logic [SW-1:0] log_syn,
  output logic          log_ue,
  output logic          log_ovf
);
  logic take, spill;

  assign take  = err_in && (!log_valid || log_clr);
  assign spill = err_in && log_valid && !log_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      log_valid <= 1'b0;
      log_ovf   <= 1'b0;
      log_addr  <= '0;
      log_syn   <= '0;
      log_ue    <= 1'b0;
    end else begin
      if (take) begin
        log_valid <= 1'b1;
        log_addr  <= err_addr_in;
        log_syn   <= err_syn_in;
        log_ue    <= err_ue_in;
      end else if (log_clr) begin
        log_valid <= 1'b0;
      end
      if (log_clr)    log_ovf <= 1'b0;
      else if (spill) log_ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/inband_ecc_splitter.sv
module inband_ecc_splitter
  import iecc_pkg::*;
#(
  parameter int AW          = 32,
  parameter int DW          = 64,
  parameter int EW          = 8,
  parameter int SW          = 8,
  parameter int NRANGE      = 2,
  parameter int CARVE_SHIFT = 5,
  parameter int LINE_BYTES  = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                cfg_mode,
  input  logic [NRANGE-1:0]         cfg_rng_en,
  input  logic [NRANGE-1:0][AW-1:0] cfg_rng_base,
  input  logic [NRANGE-1:0][AW-1:0] cfg_rng_mask,
  input  logic [AW-1:0]             cfg_ecc_base,
  input  logic                      cfg_inj_en,
  input  logic [EW-1:0]             cfg_inj_mask,
  input  logic                      up_valid,
  output logic                      up_ready,
  input  logic                      up_write,
  input  logic [AW-1:0]             up_addr,
  input  logic [DW-1:0]             up_wdata,
  input  logic [EW-1:0]             up_wecc,
  output logic                      up_denied,
  output logic                      dn_valid,
  input  logic                      dn_ready,
  output logic                      dn_write,
  output logic [AW-1:0]             dn_addr,
  output logic [DW-1:0]             dn_wdata,
  output logic [EW-1:0]             dn_wecc,
  output logic                      dn_is_ecc,
  input  logic                      err_in,
  input  logic [AW-1:0]             err_addr_in,
  input  logic [SW-1:0]             err_syn_in,
  input  logic                      err_ue_in,
  input  logic                      log_clr,
  output logic                      log_valid,
  output logic [AW-1:0]             log_addr,
  output logic [SW-1:0]             log_syn,
  output logic                      log_ue,
  output logic                      log_ovf,
  output logic                      irq
);
  iecc_mode_e    mode_q;
  logic          prot, reserved_hit, fire_data, fire_ecc;
  logic [AW-1:0] ecc_addr;

  iecc_prot_decode #(
    .AW(AW), .NRANGE(NRANGE), .CARVE_SHIFT(CARVE_SHIFT), .LINE_BYTES(LINE_BYTES)
  ) u_decode (
    .mode(mode_q), .addr(up_addr), .rng_en(cfg_rng_en), .rng_base(cfg_rng_base),
    .rng_mask(cfg_rng_mask), .ecc_base(cfg_ecc_base), .prot(prot),
    .reserved_hit(reserved_hit), .ecc_addr(ecc_addr)
  );

  iecc_split_ctrl #(.AW(AW), .DW(DW), .EW(EW)) u_split (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_inj_en(cfg_inj_en),
    .cfg_inj_mask(cfg_inj_mask), .prot(prot), .reserved_hit(reserved_hit),
    .ecc_addr(ecc_addr), .mode_q(mode_q), .up_valid(up_valid), .up_ready(up_ready),
    .up_write(up_write), .up_addr(up_addr), .up_wdata(up_wdata), .up_wecc(up_wecc),
    .up_denied(up_denied), .dn_valid(dn_valid), .dn_ready(dn_ready),
    .dn_write(dn_write), .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_wecc(dn_wecc),
    .dn_is_ecc(dn_is_ecc), .fire_data(fire_data), .fire_ecc(fire_ecc)
  );

  iecc_err_log #(.AW(AW), .SW(SW)) u_log (
    .clk(clk), .rst_n(rst_n), .err_in(err_in), .err_addr_in(err_addr_in),
    .err_syn_in(err_syn_in), .err_ue_in(err_ue_in), .log_clr(log_clr),
    .log_valid(log_valid), .log_addr(log_addr), .log_syn(log_syn),
    .log_ue(log_ue), .log_ovf(log_ovf)
  );

  assign irq = log_valid;
endmodule

// File: rtl/iecc_chk.sv
module iecc_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          up_valid,
  input logic          up_ready,
  input logic          up_denied,
  input logic          dn_valid,
  input logic          dn_ready,
  input logic [AW-1:0] dn_addr,
  input logic          dn_is_ecc,
  input logic          fire_data,
  input logic          err_in,
  input logic [AW-1:0] err_addr_in,
  input logic          log_clr,
  input logic          log_valid,
  input logic [AW-1:0] log_addr,
  input logic          log_ovf
);
  // R5
  dn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_addr) && $stable(dn_is_ecc));

  // R5
  done_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && up_ready && !up_denied |-> dn_valid && dn_ready);

  // R4
  ecc_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_data && !up_ready |=> dn_valid && dn_is_ecc);

  // R6
  deny_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_denied |-> up_ready && !dn_valid);

  // R9
  first_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_in && !log_valid |=> log_valid && log_addr == $past(err_addr_in));

  // R10
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_in && log_valid && !log_clr |=> log_ovf && $stable(log_addr));

  // R10
  clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    log_clr && !err_in |=> !log_valid && !log_ovf);
endmodule

bind inband_ecc_splitter iecc_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready),
  .up_denied(up_denied), .dn_valid(dn_valid), .dn_ready(dn_ready),
  .dn_addr(dn_addr), .dn_is_ecc(dn_is_ecc), .fire_data(fire_data),
  .err_in(err_in), .err_addr_in(err_addr_in), .log_clr(log_clr),
  .log_valid(log_valid), .log_addr(log_addr), .log_ovf(log_ovf)
);

// File: tb/inband_ecc_splitter_tb.sv
`timescale 1ns/1ps
module inband_ecc_splitter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]       cfg_mode = 2'd1;
  logic [1:0]       cfg_rng_en = 2'b00;
  logic [1:0][31:0] cfg_rng_base = '0;
  logic [1:0][31:0] cfg_rng_mask = '0;
  logic [31:0]      cfg_ecc_base = 32'hF800_0000;
  logic             cfg_inj_en = 1'b0;
  logic [7:0]       cfg_inj_mask = 8'h81;
  logic             up_valid = 1'b0, up_write = 1'b0;
  logic [31:0]      up_addr = '0;
  logic [63:0]      up_wdata = '0;
  logic [7:0]       up_wecc = '0;
  logic             dn_ready = 1'b1;
  logic             err_in = 1'b0, err_ue_in = 1'b0, log_clr = 1'b0;
  logic [31:0]      err_addr_in = '0;
  logic [7:0]       err_syn_in = '0;
  logic             up_ready, up_denied, dn_valid, dn_write, dn_is_ecc;
  logic [31:0]      dn_addr, log_addr;
  logic [63:0]      dn_wdata;
  logic [7:0]       dn_wecc, log_syn;
  logic             log_valid, log_ue, log_ovf, irq;

  inband_ecc_splitter u_dut (.*);

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int rdy_mode = 0;        // 0 always ready, 1 stall pattern, 2 manual
  logic rdy_man = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp,
                     input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] line_of(input logic [31:0] a);
    longint unsigned s;
    s = (longint'(a) / 32) / 64 * 64;
    return cfg_ecc_base + 32'(s);
  endfunction

  // reference model state
  int m_ph = 0, m_md = 1;
  bit m_lv = 0, m_lo = 0, m_lu = 0;
  logic [31:0] m_la = '0;
  logic [7:0]  m_ls = '0;

  always @(negedge clk) begin
    bit hit, prot, rsv, e_v, e_r, e_d, e_e;
    logic [31:0] e_a;
    logic [63:0] e_wd;
    logic [7:0]  e_we;
    string tagv;
    cyc++;
    if (!rst_n) begin
      m_ph = 0; m_md = 1; m_lv = 0; m_lo = 0;
      chk("R11", dn_valid, 0, "dn_valid");
      chk("R11", irq, 0, "irq");
      chk("R11", log_ovf, 0, "log_ovf");
    end else begin
      rsv = (up_addr >> 27) == (cfg_ecc_base >> 27);
      hit = 0;
      for (int g = 0; g < 2; g++)
        if (cfg_rng_en[g] && (up_addr & cfg_rng_mask[g]) == cfg_rng_base[g]) hit = 1;
      prot = (m_md == 0) ? hit : (m_md == 2);
      e_v = 0; e_r = 0; e_d = 0; e_e = 0; e_a = up_addr; e_wd = up_wdata; e_we = 0;
      if (up_valid) begin
        if (m_ph == 0) begin
          if (rsv) begin e_r = 1; e_d = 1; end
          else begin e_v = 1; e_r = !prot && dn_ready; end
        end else begin
          e_v = 1; e_e = 1; e_a = line_of(up_addr); e_wd = 0;
          e_we = up_wecc ^ ((cfg_inj_en && up_write) ? cfg_inj_mask : 8'h00);
          e_r = dn_ready;
        end
      end
      if (rsv) tagv = "R6";
      else if (m_md != int'(cfg_mode)) tagv = "R8";
      else if (m_md == 0) tagv = "R1";
      else if (m_md == 2) tagv = "R3";
      else tagv = "R2";
      chk(tagv, dn_valid, e_v, "dn_valid");
      chk("R5", up_ready, e_r, "up_ready");
      chk("R6", up_denied, e_d, "up_denied");
      if (e_v) begin
        chk(tagv, dn_is_ecc, e_e, "dn_is_ecc");
        chk("R4", dn_addr, e_a, "dn_addr");
        chk("R4", dn_write, up_write, "dn_write");
        chk("R4", dn_wdata, e_wd, "dn_wdata");
        chk("R7", dn_wecc, e_we, "dn_wecc");
      end
      chk("R9", log_valid, m_lv, "log_valid");
      chk("R9", irq, m_lv, "irq");
      chk("R10", log_ovf, m_lo, "log_ovf");
      if (m_lv) begin
        chk("R9", log_addr, m_la, "log_addr");
        chk("R9", log_syn, m_ls, "log_syn");
        chk("R9", log_ue, m_lu, "log_ue");
      end
      // advance model to the next edge
      if (m_ph == 0 && e_v && dn_ready && prot) m_ph = 1;
      else if (m_ph == 1 && dn_ready) m_ph = 0;
      if (!up_valid || e_r) m_md = int'(cfg_mode);
      if (log_clr) begin m_lv = 0; m_lo = 0; end
      if (err_in) begin
        if (!m_lv) begin m_lv = 1; m_la = err_addr_in; m_ls = err_syn_in; m_lu = err_ue_in; end
        else m_lo = 1;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    case (rdy_mode)
      0: dn_ready = 1'b1;
      1: dn_ready = (cyc % 3) != 0;
      default: dn_ready = rdy_man;
    endcase
  end

  task automatic req(input logic w, input logic [31:0] a, input logic [7:0] e);
    @(posedge clk); #2;
    up_valid = 1; up_write = w; up_addr = a; up_wdata = {a, ~a}; up_wecc = e;
    do @(negedge clk); while (!up_ready);
    @(posedge clk); #2;
    up_valid = 0;
  endtask

  task automatic err(input logic [31:0] a, input logic [7:0] s, input logic ue, input logic clr);
    @(posedge clk); #2;
    err_in = 1; err_addr_in = a; err_syn_in = s; err_ue_in = ue; log_clr = clr;
    @(posedge clk); #2;
    err_in = 0; log_clr = 0;
  endtask

  task automatic clear();
    @(posedge clk); #2; log_clr = 1;
    @(posedge clk); #2; log_clr = 0;
  endtask

  task automatic sweep();
    req(1, 32'h0012_3440, 8'h3C);   // window 0
    req(0, 32'h0020_0000, 8'h11);   // no window
    req(1, 32'h4ABC_0000, 8'h5A);   // window 1
    req(0, 32'h8000_1000, 8'h22);   // no window
    req(1, 32'hF900_0000, 8'h44);   // carve-out
  endtask

  initial begin
    cfg_rng_base[0] = 32'h0010_0000; cfg_rng_mask[0] = 32'hFFF0_0000;
    cfg_rng_base[1] = 32'h4000_0000; cfg_rng_mask[1] = 32'hC000_0000;
    cfg_rng_en = 2'b11;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R2: mode 1 single beats
    sweep();
    // R3: mode 2, with downstream stalls (R5)
    cfg_mode = 2; rdy_mode = 1;
    sweep();
    // R1: mode 0 windows, then window 1 disabled
    cfg_mode = 0;
    sweep();
    cfg_rng_en = 2'b01;
    sweep();
    cfg_rng_en = 2'b11;
    // R2: mode 3 behaves as off
    cfg_mode = 3; rdy_mode = 0;
    sweep();
    // R7: injection on writes only
    cfg_mode = 2; cfg_inj_en = 1;
    req(1, 32'h0000_1FC0, 8'hF0);
    req(0, 32'h0000_1FC0, 8'h0F);
    req(1, 32'h7FFF_FFC0, 8'hAA);
    cfg_inj_en = 0;
    req(1, 32'h0000_1FC0, 8'hF0);
    // R8: mode change while a split is in its check-line phase
    rdy_mode = 2; rdy_man = 0;
    @(posedge clk); #2;
    up_valid = 1; up_write = 1; up_addr = 32'h0123_4560; up_wdata = 64'h1; up_wecc = 8'h77;
    repeat (2) @(posedge clk);
    rdy_man = 1; @(posedge clk); rdy_man = 0;
    #2 cfg_mode = 1;
    repeat (3) @(posedge clk);
    rdy_man = 1;
    do @(negedge clk); while (!up_ready);
    @(posedge clk); #2 up_valid = 0;
    rdy_mode = 0;
    req(1, 32'h0123_4560, 8'h77);
    // R9 / R10: log behaviour
    err(32'hDEAD_0040, 8'h5C, 0, 0);
    repeat (2) @(posedge clk);
    err(32'hBEEF_0080, 8'h13, 1, 0);
    clear();
    err(32'h0000_0100, 8'h01, 1, 0);
    err(32'h0000_0200, 8'h02, 0, 1);
    repeat (3) @(posedge clk);
    clear();
    repeat (3) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule